// File: doc/BRIEF.md
# DMA Descriptor List Walker

This block walks a list of DMA descriptors held in system memory. Each descriptor is four 32-bit words: a status word with an ownership flag, a control word with layout flags and two buffer sizes, and two address words. Through a simple request/response memory port the walker reads the four words of the current descriptor. If hardware owns the descriptor, the walker offers the described buffers as address/size pairs to a data mover, one at a time. It then writes the status word back with ownership handed to the host and works out where the next descriptor lives.

Two list layouts are supported. In the ring layout, descriptors sit 16 bytes apart and an end-of-ring flag sends the walker back to the list base. In the chained layout, the second address word links to the next descriptor instead of naming a data buffer. A start/poll pulse begins a walk from the list base. The same pulse also wakes the walker after it has stopped on a host-owned descriptor. The data transfer itself and the meaning of the other status bits belong to other blocks.

Top module: `desc_walker`

## Requirements
- R1: After reset the walker is idle: `mem_req`, `buf_valid`, `stalled` and `align_err` are all low.
- R2: A start pulse while idle with `list_base[1:0]` not zero sets `align_err` and issues no memory request. A start pulse with an aligned base clears `align_err` and begins a walk at `list_base`.
- R3: For each descriptor at address A the walker reads A (status), A+4 (control), A+8 (first address) and A+12 (second address), in that order. Each request is held with a stable address until `mem_rvalid`.
- R4: If status bit 31 is 0 (host-owned), the walker stops without reading the rest of the descriptor and raises `stalled`. It issues no requests until a start pulse, which re-reads the same address.
- R5: Buffer one (address word A+8, size = control bits 10:0) is offered before buffer two (address word A+12, size = control bits 21:11). Each offer holds `buf_addr` and `buf_size` steady until `buf_ready`.
- R6: A buffer whose size field is zero is never offered.
- R7: When control bit 24 (chained) is set and bit 25 is clear, buffer two is not offered and the next descriptor address is the word read from A+12.
- R8: When control bit 25 (end of ring) is set, the next descriptor address is the list base. This holds whether or not bit 24 is set. With bit 25 set, buffer two is still offered if its size is non-zero.
- R9: With bits 24 and 25 both clear, the next descriptor address is A+16.
- R10: After the buffers, the walker writes address A with the stored status word, bit 31 cleared and every other bit unchanged, before it reads the next descriptor.
- R11: A start pulse during an active walk has no effect on the memory or buffer traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| list_base | input | ADDR_W | Byte address of the first descriptor |
| start | input | 1 | Start pulse when idle, poll pulse when stalled |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data (status write-back) |
| mem_rvalid | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Read data |
| buf_valid | output | 1 | Buffer offer to the data mover |
| buf_addr | output | ADDR_W | Buffer start address |
| buf_size | output | 11 | Buffer size in bytes |
| buf_ready | input | 1 | Data mover accepts the offer |
| stalled | output | 1 | Stopped on a host-owned descriptor |
| align_err | output | 1 | Last start was refused for a misaligned base |

## Verification
The walk is driven through a short list that mixes every layout: two plain ring descriptors, one chained descriptor with a non-zero buffer-two size that must be ignored, and one descriptor with both end-of-ring and chained set. A wrong next address, a buffer offered that should have been skipped, or a missing write-back therefore shows up as a mismatch in the access stream. Buffer-one sizes of zero and both sizes zero separate skip handling from the normal two-buffer case. The data mover's ready line follows an irregular pattern, which exposes offers that are not held steady. Returning to a descriptor the walker itself released checks the stop on ownership, and a later poll checks that the walk resumes at the same address. A misaligned start and a start in the middle of a walk check the two cases where a start pulse must not begin normal traffic.

// File: rtl/desc_walker_pkg.sv
package desc_walker_pkg;
    localparam int WORD_W     = 32;
    localparam int OWN_BIT    = 31;
    localparam int RING_END   = 25;
    localparam int LINK_BIT   = 24;
    localparam int SZ_W       = 11;
    localparam int SZ1_LSB    = 0;
    localparam int SZ2_LSB    = 11;
    localparam int DESC_BYTES = 16;

    typedef enum logic [3:0] {
        W_IDLE, W_RD_STAT, W_RD_CTRL, W_RD_PTR1, W_RD_PTR2,
        W_OFFER1, W_OFFER2, W_WBACK, W_STALL
    } wstate_e;
endpackage

// File: rtl/desc_next_addr.sv
module desc_next_addr
    import desc_walker_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [ADDR_W-1:0] link_addr,
    input  logic              ring_end,
    input  logic              linked,
    output logic [ADDR_W-1:0] next_addr
);
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(DESC_BYTES);

    always_comb begin
        if (ring_end)    next_addr = base_addr;
        else if (linked) next_addr = link_addr;
        else             next_addr = cur_addr + STRIDE;
    end
endmodule

// File: rtl/desc_slot_gate.sv
module desc_slot_gate
    import desc_walker_pkg::*;
(
    input  logic [SZ_W-1:0] size1,
    input  logic [SZ_W-1:0] size2,
    input  logic            ring_end,
    input  logic            linked,
    output logic            use1,
    output logic            use2
);
    always_comb begin
        use1 = (size1 != '0);
        use2 = (size2 != '0) && (ring_end || !linked);
    end
endmodule

// File: rtl/desc_walker.sv
module desc_walker
    import desc_walker_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] list_base,
    input  logic              start,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              buf_valid,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [SZ_W-1:0]   buf_size,
    input  logic              buf_ready,
    output logic              stalled,
    output logic              align_err
);
    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_PTR1 = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFS_PTR2 = ADDR_W'(12);

    typedef struct packed {
        wstate_e           st;
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] base;
        logic [WORD_W-1:0] stat;
        logic              ring_end;
        logic              linked;
        logic [SZ_W-1:0]   size1;
        logic [SZ_W-1:0]   size2;
        logic [ADDR_W-1:0] ptr1;
        logic [ADDR_W-1:0] ptr2;
        logic              aerr;
    } walk_t;

    walk_t             walk_d, walk_q;
    logic [ADDR_W-1:0] next_addr_d;
    logic              use1_d, use2_d;

    desc_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .cur_addr  (walk_q.cur),
        .base_addr (walk_q.base),
        .link_addr (walk_q.ptr2),
        .ring_end  (walk_q.ring_end),
        .linked    (walk_q.linked),
        .next_addr (next_addr_d)
    );

    desc_slot_gate u_gate (
        .size1    (walk_q.size1),
        .size2    (walk_q.size2),
        .ring_end (walk_q.ring_end),
        .linked   (walk_q.linked),
        .use1     (use1_d),
        .use2     (use2_d)
    );

    always_comb begin
        walk_d    = walk_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = walk_q.cur;
        mem_wdata = walk_q.stat;
        mem_wdata[OWN_BIT] = 1'b0;
        buf_valid = 1'b0;
        buf_addr  = walk_q.ptr1;
        buf_size  = walk_q.size1;

        unique case (walk_q.st)
            W_IDLE: begin
                if (start) begin
                    if (list_base[1:0] != 2'b00) begin
                        walk_d.aerr = 1'b1;
                    end else begin
                        walk_d.aerr = 1'b0;
                        walk_d.base = list_base;
                        walk_d.cur  = list_base;
                        walk_d.st   = W_RD_STAT;
                    end
                end
            end
            W_RD_STAT: begin
                mem_req = 1'b1;
                if (mem_rvalid) begin
                    walk_d.stat = mem_rdata;
                    walk_d.st   = mem_rdata[OWN_BIT] ? W_RD_CTRL : W_STALL;
                end
            end
            W_RD_CTRL: begin
                mem_req  = 1'b1;
                mem_addr = walk_q.cur + OFS_CTRL;
                if (mem_rvalid) begin
                    walk_d.ring_end = mem_rdata[RING_END];
                    walk_d.linked   = mem_rdata[LINK_BIT];
                    walk_d.size1    = mem_rdata[SZ1_LSB +: SZ_W];
                    walk_d.size2    = mem_rdata[SZ2_LSB +: SZ_W];
                    walk_d.st       = W_RD_PTR1;
                end
            end
            W_RD_PTR1: begin
                mem_req  = 1'b1;
                mem_addr = walk_q.cur + OFS_PTR1;
                if (mem_rvalid) begin
                    walk_d.ptr1 = mem_rdata[ADDR_W-1:0];
                    walk_d.st   = W_RD_PTR2;
                end
            end
            W_RD_PTR2: begin
                mem_req  = 1'b1;
                mem_addr = walk_q.cur + OFS_PTR2;
                if (mem_rvalid) begin
                    walk_d.ptr2 = mem_rdata[ADDR_W-1:0];
                    walk_d.st   = W_OFFER1;
                end
            end
            W_OFFER1: begin
                buf_valid = use1_d;
                if (!use1_d || buf_ready) walk_d.st = W_OFFER2;
            end
            W_OFFER2: begin
                buf_valid = use2_d;
                buf_addr  = walk_q.ptr2;
                buf_size  = walk_q.size2;
                if (!use2_d || buf_ready) walk_d.st = W_WBACK;
            end
            W_WBACK: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_rvalid) begin
                    walk_d.cur = next_addr_d;
                    walk_d.st  = W_RD_STAT;
                end
            end
            W_STALL: begin
                if (start) walk_d.st = W_RD_STAT;
            end
            default: walk_d.st = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) walk_q <= '0;
        else        walk_q <= walk_d;
    end

    assign stalled   = (walk_q.st == W_STALL);
    assign align_err = walk_q.aerr;
endmodule

// File: rtl/desc_walker_chk.sv
module desc_walker_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       mem_wdata,
    input logic              mem_rvalid,
    input logic              buf_valid,
    input logic [ADDR_W-1:0] buf_addr,
    input logic [10:0]       buf_size,
    input logic              buf_ready,
    input logic              stalled,
    input logic              align_err
);
    // R5
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid && !buf_ready |=> buf_valid && $stable(buf_addr) && $stable(buf_size));
    // R6
    no_empty_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |-> buf_size != 11'd0);
    // R4
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stalled |-> !mem_req && !buf_valid);
    // R2
    align_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !mem_req);
    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr) && $stable(mem_we));
    // R3
    word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);
    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> !mem_wdata[31]);
    // R5
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_valid && mem_req));
endmodule

bind desc_walker desc_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_rvalid (mem_rvalid),
    .buf_valid  (buf_valid),
    .buf_addr   (buf_addr),
    .buf_size   (buf_size),
    .buf_ready  (buf_ready),
    .stalled    (stalled),
    .align_err  (align_err)
);

// File: tb/sim_desc_walker.sv
module sim_desc_walker;
    localparam int AW = 32;

    typedef struct {
        int          kind;   // 0 read, 1 write, 2 buffer offer
        logic [31:0] addr;
        logic [31:0] val;
        string       tag;
    } ev_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] list_base = '0;
    logic          start = 1'b0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          buf_valid;
    logic [AW-1:0] buf_addr;
    logic [10:0]   buf_size;
    logic          buf_ready = 1'b0;
    logic          stalled, align_err;

    logic [31:0] mem [0:127];
    ev_t         expq[$];
    int          n_tests = 0;
    int          n_fail  = 0;
    int          cyc     = 0;

    always #5 clk = ~clk;

    desc_walker #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .list_base(list_base), .start(start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .buf_valid(buf_valid), .buf_addr(buf_addr), .buf_size(buf_size),
        .buf_ready(buf_ready), .stalled(stalled), .align_err(align_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic exp_rd(input logic [31:0] a, input string tag);
        expq.push_back('{0, a, 32'h0, tag});
    endtask
    task automatic exp_wr(input logic [31:0] a, input logic [31:0] d, input string tag);
        expq.push_back('{1, a, d, tag});
    endtask
    task automatic exp_buf(input logic [31:0] a, input logic [31:0] s, input string tag);
        expq.push_back('{2, a, s, tag});
    endtask
    task automatic exp_desc_reads(input logic [31:0] a, input string tag);
        for (int k = 0; k < 4; k++) exp_rd(a + 32'(4 * k), tag);
    endtask

    task automatic observe(input int kind, input logic [31:0] a, input logic [31:0] v);
        ev_t e;
        if (expq.size() == 0) begin
            check(1'b0, "R11", "unexpected event kind/addr", a, {28'h0, 4'(kind)});
            return;
        end
        e = expq.pop_front();
        check(e.kind == kind && e.addr == a, e.tag, "event address", a, e.addr);
        if (kind != 0) check(e.val == v, e.tag, "event data/size", v, e.val);
    endtask

    // memory responder, ready pattern and monitor in one process
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            buf_ready  = (cyc % 3) != 1;
            mem_rvalid = 1'b0;
            if (rst_n && mem_req) begin
                mem_rvalid = 1'b1;
                if (mem_we) begin
                    mem[mem_addr[8:2]] = mem_wdata;
                    observe(1, mem_addr, mem_wdata);
                end else begin
                    mem_rdata = mem[mem_addr[8:2]];
                    observe(0, mem_addr, 32'h0);
                end
            end
            if (rst_n && buf_valid && buf_ready)
                observe(2, buf_addr, {21'h0, buf_size});
        end
    end

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic drain(input string tag);
        int t = 0;
        while (expq.size() != 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        check(expq.size() == 0, tag, "pending expected events", expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        #1000000;
        check(1'b0, "R1", "watchdog expired", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = '0;
        // plain ring descriptor at 0x00: both buffers
        mem[0]  = 32'h8000_00A5; mem[1]  = 32'h0001_0040;
        mem[2]  = 32'h0000_0100; mem[3]  = 32'h0000_0140;
        // plain ring at 0x10: buffer one size zero
        mem[4]  = 32'h8000_0001; mem[5]  = 32'h0000_A000;
        mem[6]  = 32'h0000_0999; mem[7]  = 32'h0000_0160;
        // chained at 0x20: buffer two size 12 ignored, link to 0x40
        mem[8]  = 32'h8000_0000; mem[9]  = 32'h0100_6008;
        mem[10] = 32'h0000_0180; mem[11] = 32'h0000_0040;
        // end of ring plus chained at 0x40
        mem[16] = 32'h8000_0F00; mem[17] = 32'h0300_4004;
        mem[18] = 32'h0000_01C0; mem[19] = 32'h0000_01F0;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(mem_req == 1'b0,   "R1", "mem_req after reset",   mem_req, 0);
        check(buf_valid == 1'b0, "R1", "buf_valid after reset", buf_valid, 0);
        check(stalled == 1'b0,   "R1", "stalled after reset",   stalled, 0);
        check(align_err == 1'b0, "R1", "align_err after reset", align_err, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 misaligned start: no traffic expected
        list_base = 32'h0000_0002;
        pulse_start();
        repeat (4) @(negedge clk);
        check(align_err == 1'b1, "R2", "align_err on misaligned base", align_err, 1);
        check(stalled == 1'b0,   "R2", "no walk on misaligned base", stalled, 0);

        // main walk: R3 R5 R6 R7 R8 R9 R10
        exp_desc_reads(32'h00, "R3");
        exp_buf(32'h100, 64, "R5");
        exp_buf(32'h140, 32, "R5");
        exp_wr(32'h00, 32'h0000_00A5, "R10");
        exp_desc_reads(32'h10, "R9");
        exp_buf(32'h160, 20, "R6");
        exp_wr(32'h10, 32'h0000_0001, "R10");
        exp_desc_reads(32'h20, "R9");
        exp_buf(32'h180, 8, "R7");
        exp_wr(32'h20, 32'h0000_0000, "R10");
        exp_desc_reads(32'h40, "R7");
        exp_buf(32'h1C0, 4, "R8");
        exp_buf(32'h1F0, 8, "R8");
        exp_wr(32'h40, 32'h0000_0F00, "R10");
        exp_rd(32'h00, "R8");
        list_base = 32'h0000_0000;
        pulse_start();
        @(negedge clk);
        check(align_err == 1'b0, "R2", "align_err cleared by aligned start", align_err, 0);
        repeat (5) @(negedge clk);
        pulse_start();   // R11: must be ignored mid-walk
        drain("R8");
        check(stalled == 1'b1, "R4", "stalled on host-owned descriptor", stalled, 1);
        repeat (10) @(negedge clk);
        check(stalled == 1'b1, "R4", "still stalled without poll", stalled, 1);

        // R4 poll resumes at same address; both sizes zero, ring step to 0x10
        mem[0] = 32'h8000_0077;
        mem[1] = 32'h0000_0000;
        exp_desc_reads(32'h00, "R4");
        exp_wr(32'h00, 32'h0000_0077, "R10");
        exp_rd(32'h10, "R9");
        pulse_start();
        drain("R4");
        check(stalled == 1'b1, "R4", "stalled on released descriptor", stalled, 1);
        check(mem[0] == 32'h0000_0077, "R10", "written status word", mem[0], 32'h77);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule